// File: doc/BRIEF.md
# Row Hit-Run Finder

This block compresses one row of binary pixel hits from a 64-column group into a short list of run descriptors. A row arrives as a 64-bit hit vector with a row address and a valid strobe; the block finds every stretch of neighbouring set bits and reports each one as its first column and its length. Rows are handled one at a time and independently of each other.

Each descriptor covers at most four pixels, so a longer stretch is cut into consecutive four-pixel pieces from its low end, with the remainder last. At most six pieces are reported per row, taken in ascending column order. If a row holds more pieces, the extra ones are dropped and the row is flagged as overflowed. The result appears a fixed two cycles after the strobe, and a new row may be presented on every cycle without stalls, so rows can be streamed continuously.

Top module: `row_run_finder`

## Requirements
- R1: A row presented with `rowValid` high is reported with `outValid` high for exactly one cycle, two clock edges after the edge that captured it. A new row can be accepted on every cycle.
- R2: Each 8-bit descriptor holds the start column in bits 7:2 and a length code in bits 1:0, where code n means n+1 pixels.
- R3: When a row yields more than six pieces, the first six in column order are reported and `overflow` is 1. When it yields six or fewer, `overflow` is 0.
- R4: A stretch of more than four set bits is reported as four-pixel pieces starting at its lowest column, followed by one piece holding the remaining one to three pixels.
- R5: Descriptor slot i occupies `descList` bits 8i+7:8i. `descMask` has its low k bits set for k reported pieces. Slots are in ascending start-column order, and unused slots read zero.
- R6: `outRow` equals the `rowAddr` presented with the row being reported.
- R7: A row with no set bits gives `outValid` 1, `descMask` 0 and `overflow` 0.
- R8: During and right after reset, `outValid`, `descMask` and `overflow` are 0.
- R9: A cycle with `rowValid` low produces no report two cycles later (`outValid` 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rowValid | input | 1 | Qualifies hitVec and rowAddr this cycle |
| rowAddr | input | 10 | Row number of the presented hit vector |
| hitVec | input | 64 | One bit per column, 1 means hit |
| outValid | output | 1 | Result of one row present this cycle |
| outRow | output | 10 | Row number of the reported result |
| descList | output | 48 | Six packed 8-bit run descriptors |
| descMask | output | 6 | Valid flag per descriptor slot |
| overflow | output | 1 | Row produced more than six pieces |

## Verification
The splitting of a long stretch and the six-piece cap can act in the same row: a stretch can be cut in the middle, with some of its pieces kept and the rest dropped. This is provoked with an all-ones row, with a stretch that reaches past column 63 after five earlier pieces, and with pseudo-random dense rows. Each row is judged against a reference that first finds whole stretches, then splits them, and only then applies the cap. Back-to-back rows are also streamed so that capturing one row and publishing the previous one happen in the same cycle.

// File: rtl/rhf_pkg.sv
package rhf_pkg;
  typedef struct packed {
    logic capture;
    logic publish;
  } stageStrobes_t;
endpackage

// File: rtl/rhf_ctrl.sv
module rhf_ctrl
  import rhf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rowValid,
  output stageStrobes_t strobes,
  output logic          outValid
);
  logic stage1Valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      stage1Valid <= rowValid;
      outValid    <= stage1Valid;
    end
  end

  assign strobes.capture = rowValid;
  assign strobes.publish = stage1Valid;
endmodule

// File: rtl/rhf_datapath.sv
module rhf_datapath
  import rhf_pkg::*;
#(
  parameter int COLS     = 64,
  parameter int MAX_RUNS = 6,
  parameter int MAX_LEN  = 4,
  parameter int ROW_W    = 10,
  localparam int COL_W   = $clog2(COLS),
  localparam int LEN_W   = $clog2(MAX_LEN),
  localparam int DESC_W  = COL_W + LEN_W,
  localparam int SLOT_W  = (MAX_RUNS > 1) ? $clog2(MAX_RUNS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  stageStrobes_t              strobes,
  input  logic [ROW_W-1:0]           rowAddr,
  input  logic [COLS-1:0]            hitVec,
  output logic [ROW_W-1:0]           outRow,
  output logic [MAX_RUNS*DESC_W-1:0] descList,
  output logic [MAX_RUNS-1:0]        descMask,
  output logic                       overflow
);
  logic [COLS-1:0]  hitReg;
  logic [ROW_W-1:0] rowReg;

  logic [MAX_RUNS-1:0][DESC_W-1:0] slotNext;
  logic [MAX_RUNS-1:0]             maskNext;
  logic                            ovfNext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hitReg <= '0;
      rowReg <= '0;
    end else if (strobes.capture) begin
      hitReg <= hitVec;
      rowReg <= rowAddr;
    end
  end

  // Column scan from 0 upward; pieces close at MAX_LEN pixels.
  always_comb begin
    int pieceLen;
    int count;
    logic kept;
    slotNext = '0;
    maskNext = '0;
    ovfNext  = 1'b0;
    pieceLen = 0;
    count    = 0;
    kept     = 1'b0;
    for (int c = 0; c < COLS; c++) begin
      if (hitReg[c]) begin
        if (pieceLen == 0 || pieceLen == MAX_LEN) begin
          pieceLen = 1;
          if (count < MAX_RUNS) begin
            slotNext[SLOT_W'(count)] = {COL_W'(c), LEN_W'(0)};
            maskNext[SLOT_W'(count)] = 1'b1;
            count = count + 1;
            kept  = 1'b1;
          end else begin
            kept    = 1'b0;
            ovfNext = 1'b1;
          end
        end else begin
          pieceLen = pieceLen + 1;
          if (kept)
            slotNext[SLOT_W'(count - 1)][LEN_W-1:0] = LEN_W'(pieceLen - 1);
        end
      end else begin
        pieceLen = 0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outRow   <= '0;
      descList <= '0;
      descMask <= '0;
      overflow <= 1'b0;
    end else if (strobes.publish) begin
      outRow   <= rowReg;
      descList <= slotNext;
      descMask <= maskNext;
      overflow <= ovfNext;
    end
  end
endmodule

// File: rtl/row_run_finder.sv
module row_run_finder
  import rhf_pkg::*;
#(
  parameter int COLS     = 64,
  parameter int MAX_RUNS = 6,
  parameter int MAX_LEN  = 4,
  parameter int ROW_W    = 10,
  localparam int DESC_W  = $clog2(COLS) + $clog2(MAX_LEN)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rowValid,
  input  logic [ROW_W-1:0]           rowAddr,
  input  logic [COLS-1:0]            hitVec,
  output logic                       outValid,
  output logic [ROW_W-1:0]           outRow,
  output logic [MAX_RUNS*DESC_W-1:0] descList,
  output logic [MAX_RUNS-1:0]        descMask,
  output logic                       overflow
);
  stageStrobes_t strobes;

  rhf_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rowValid (rowValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  rhf_datapath #(
    .COLS     (COLS),
    .MAX_RUNS (MAX_RUNS),
    .MAX_LEN  (MAX_LEN),
    .ROW_W    (ROW_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .rowAddr  (rowAddr),
    .hitVec   (hitVec),
    .outRow   (outRow),
    .descList (descList),
    .descMask (descMask),
    .overflow (overflow)
  );
endmodule

// File: rtl/rhf_checker.sv
module rhf_checker #(
  parameter int COLS     = 64,
  parameter int MAX_RUNS = 6,
  parameter int MAX_LEN  = 4,
  parameter int ROW_W    = 10,
  localparam int COL_W   = $clog2(COLS),
  localparam int LEN_W   = $clog2(MAX_LEN),
  localparam int DESC_W  = COL_W + LEN_W
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rowValid,
  input logic [ROW_W-1:0]           rowAddr,
  input logic                       outValid,
  input logic [ROW_W-1:0]           outRow,
  input logic [MAX_RUNS*DESC_W-1:0] descList,
  input logic [MAX_RUNS-1:0]        descMask,
  input logic                       overflow
);
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rowValid |=> ##1 outValid);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rowValid |=> ##1 !outValid);

  p_row_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rowValid |=> ##1 (outRow == $past(rowAddr, 2)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (&descMask));

  p_mask_packed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((descMask & (descMask + 1'b1)) == '0));

  p_reset_quiet_r8: assert property (@(posedge clk)
    $past(!rst_n) |-> (!outValid && descMask == '0 && !overflow));

  for (genvar i = 0; i + 1 < MAX_RUNS; i++) begin : g_order
    p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
      descMask[i+1] |->
        (descList[(i+1)*DESC_W+LEN_W +: COL_W] > descList[i*DESC_W+LEN_W +: COL_W]));
  end

  for (genvar i = 0; i < MAX_RUNS; i++) begin : g_unused
    p_unused_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !descMask[i] |-> (descList[i*DESC_W +: DESC_W] == '0));
  end
endmodule

bind row_run_finder rhf_checker #(
  .COLS     (COLS),
  .MAX_RUNS (MAX_RUNS),
  .MAX_LEN  (MAX_LEN),
  .ROW_W    (ROW_W)
) u_rhf_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .rowValid (rowValid),
  .rowAddr  (rowAddr),
  .outValid (outValid),
  .outRow   (outRow),
  .descList (descList),
  .descMask (descMask),
  .overflow (overflow)
);

// File: tb/row_run_finder_bench.sv
`timescale 1ns/1ps
module row_run_finder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rowValid = 1'b0;
  logic [9:0]  rowAddr = '0;
  logic [63:0] hitVec = '0;
  logic        outValid;
  logic [9:0]  outRow;
  logic [47:0] descList;
  logic [5:0]  descMask;
  logic        overflow;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    int          due;
    logic [9:0]  row;
    logic [47:0] desc;
    logic [5:0]  mask;
    logic        ovf;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  row_run_finder u_row_run_finder (
    .clk(clk), .rst_n(rst_n), .rowValid(rowValid), .rowAddr(rowAddr),
    .hitVec(hitVec), .outValid(outValid), .outRow(outRow),
    .descList(descList), .descMask(descMask), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Reference: whole stretches first, then 4-pixel split, then cap of 6.
  function automatic void refModel(input logic [63:0] h, output logic [47:0] d,
                                   output logic [5:0] m, output logic o);
    int n, c, s, len, piece;
    n = 0; c = 0; d = '0; m = '0; o = 1'b0;
    while (c < 64) begin
      if (!h[c]) begin
        c++;
      end else begin
        s = c;
        while (c < 64 && h[c]) c++;
        len = c - s;
        for (int p = s; p < s + len; p += 4) begin
          piece = (s + len - p > 4) ? 4 : s + len - p;
          if (n < 6) begin
            d[n*8 +: 8] = {6'(p), 2'(piece - 1)};
            m[n] = 1'b1;
            n++;
          end else begin
            o = 1'b1;
          end
        end
      end
    end
  endfunction

  task automatic sendRow(input logic [9:0] row, input logic [63:0] h, input string tag);
    expItem_t it;
    @(negedge clk);
    rowValid = 1'b1;
    rowAddr  = row;
    hitVec   = h;
    refModel(h, it.desc, it.mask, it.ovf);
    it.due = cyc + 2;
    it.row = row;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rowValid = 1'b0;
      hitVec   = '1;
    end
  endtask

  // Monitor: pops and compares as results emerge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R9 unexpected outValid", 64'(outValid), 64'd0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(cyc == it.due, {"R1 latency ", it.tag}, 64'(cyc), 64'(it.due));
          check(outRow == it.row, {"R6 row ", it.tag}, 64'(outRow), 64'(it.row));
          check(descList == it.desc, {"R2/R4 desc ", it.tag}, 64'(descList), 64'(it.desc));
          check(descMask == it.mask, {"R5 mask ", it.tag}, 64'(descMask), 64'(it.mask));
          check(overflow == it.ovf, {"R3 overflow ", it.tag}, 64'(overflow), 64'(it.ovf));
        end
      end else if (expQ.size() != 0 && expQ[0].due == cyc) begin
        check(1'b0, {"R1 missing outValid ", expQ[0].tag}, 64'(outValid), 64'd1);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] lfsr;
    logic [63:0] seven;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && descMask == '0 && overflow == 1'b0, "R8 in reset",
          {outValid, descMask, overflow}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && descMask == '0 && overflow == 1'b0, "R8 after reset",
          {outValid, descMask, overflow}, 64'd0);

    // Back-to-back stream of directed rows.
    sendRow(10'd1, 64'h0, "R7 empty");
    sendRow(10'd2, 64'h1, "R2 col0 single");
    sendRow(10'd3, 64'h8000_0000_0000_0000, "R2 col63 single");
    sendRow(10'd4, 64'h0000_0000_0000_3C00, "R4 run of 4");
    sendRow(10'd5, 64'h0000_0000_01F0_0000, "R4 run of 5");
    sendRow(10'd6, 64'hFF80_0000_0000_0000, "R4 run of 9 at top");
    sendRow(10'd7, 64'h0000_0000_0000_0555, "R3 exactly six");
    seven = 64'h0000_0000_0000_1555;
    sendRow(10'd8, seven, "R3 seven runs");
    sendRow(10'd9, '1, "R3 R4 all ones");
    sendRow(10'd10, 64'h5555_5555_5555_5555, "R3 alternating");
    sendRow(10'd11, 64'hFF80_0000_0000_0155, "R3 R4 split at cap");
    sendRow(10'd12, 64'h0000_0000_0000_00FF, "R4 run of 8");
    sendRow(10'd1023, 64'h0000_0000_0000_0000, "R6 max row");
    idle(4);
    check(outValid == 1'b0, "R9 idle with hits on bus", 64'(outValid), 64'd0);
    check(expQ.size() == 0, "R1 all rows reported", 64'(expQ.size()), 64'd0);

    // Pseudo-random dense rows, some with gaps between them.
    lfsr = 64'hACE1_2468_1357_9BDF;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      sendRow(10'(100 + i), lfsr | (lfsr >> 1), "R3 R4 random");
      if (i % 7 == 3) idle(1);
    end
    idle(4);
    check(expQ.size() == 0, "R1 random rows reported", 64'(expQ.size()), 64'd0);
    check(outValid == 1'b0, "R9 quiet at end", 64'(outValid), 64'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule